// File: doc/BRIEF.md
# Radix Page-Table Walker

This block walks a multi-level radix translation tree, one level per memory read. A setup stage hands it the root directory base, the initial index-mask size, the remaining shift and the page-number bits of the effective address. The walker then works through the levels. At each level it forms the address of an 8-byte directory entry and reads it over a request/acknowledge port. It then decodes the entry and either moves down one level or stops.

A walk stops in one of three ways. A leaf entry gives the physical address, which merges the page number into the leaf's real page field. An entry with its valid bit clear raises an invalid error. A malformed directory raises a bad-tree error: the size is out of range, or the tree is deeper than the level limit. The outcome is reported by a one-cycle done pulse. The result fields hold their values until the next walk starts. Permission checks and reference/change updates belong to a separate stage that consumes the leaf entry.

Top module: `radix_walk_fsm`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `rd_req` and `done` are 0, and `err_invalid`, `err_badtree`, `phys_addr` and `leaf_pte` are 0.
- R2: The first read after `start` targets an address built from the top down: 8 zero bits; root base bits 55:19; the 16-bit field at base bits 18:3, cleared under a mask and OR-ed with the index under that mask; 3 zero bits. The mask has (mask size + 5) low ones, saturating at 16. The index is the low 16 bits of the page number (address bits 61:12) shifted right by the current shift.
- R3: `rd_req` stays high with `rd_addr` unchanged until `rd_ack` is seen. Each acknowledged read returns exactly one entry.
- R4: A fetched entry with bit 63 (valid) equal to 0 ends the walk with `done` and `err_invalid`.
- R5: A valid non-leaf entry (bit 62 = 0) ends the walk with `err_badtree` when its size field (bits 4:0) is below 5, above 16, or greater than the current shift. A size equal to the shift is accepted.
- R6: A valid non-leaf entry within range causes the next read. For that read, the shift is reduced by the size, the mask size becomes size bits 3:0, and the new base is entry bits 55:8 followed by 8 zero bits. The read address uses the R2 formula with these new values.
- R7: A valid leaf entry ends the walk with no error. `leaf_pte` equals the entry. `phys_addr` is built from the top down: 8 zero bits; entry bits 55:12, cleared under a 44-bit mask with (shift) low ones and OR-ed with address bits 55:12 under that mask; entry bits 11:0.
- R8: At most 4 entries are read per walk. A valid non-leaf entry fetched as the 4th read ends the walk with `err_badtree`, and no further read is issued.
- R9: `done` is high for exactly one cycle per walk, and at most one error flag is set. The result outputs hold until the next accepted `start`. On an error, `phys_addr` and `leaf_pte` are 0.
- R10: `start` is ignored while a walk is in progress. It changes neither the read addresses nor the outcome of the walk in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a walk with the setup values (accepted when idle) |
| start_page | input | 50 | Effective address bits 61:12 |
| start_base | input | 53 | Root directory base, address bits 55:3 |
| start_msize | input | 4 | Initial index-mask size |
| start_shift | input | 6 | Initial remaining shift |
| rd_req | output | 1 | Entry read request |
| rd_addr | output | 64 | Entry byte address, 8-byte aligned |
| rd_ack | input | 1 | Read acknowledge; data valid this cycle |
| rd_data | input | 64 | Entry read data |
| done | output | 1 | One-cycle walk completion pulse |
| err_invalid | output | 1 | Walk ended on an entry with valid = 0 |
| err_badtree | output | 1 | Walk ended on a malformed or too-deep tree |
| leaf_pte | output | 64 | Leaf entry of a successful walk |
| phys_addr | output | 64 | Translated physical address |

## Verification
The hardest case to reach from the ports is the depth limit. It takes a chain of four valid directory entries whose sizes all fit the shrinking shift. Random entries rarely produce such a chain before an invalid entry, a leaf or an oversized size cuts the walk short. Directed walks therefore build that chain on purpose, along with the 3-directory-plus-leaf walk just below the limit and the size-equals-shift edge. Random walks with biased entry kinds and varying acknowledge delays cover the address merging. Some walks pulse `start` while a read is pending.

// File: rtl/radix_walk_pkg.sv
// Package: shared constants, field positions and state type of the radix walker.
// Assumes 64-bit entries and addresses; all positions are little-endian bit numbers.
package radix_walk_pkg;
    localparam int PA_W      = 64;   // address and entry width
    localparam int PA_TOP    = 56;   // meaningful physical address bits (55:0)
    localparam int IDX_LO    = 3;    // entries are 8-byte aligned
    localparam int IDX_W     = 16;   // width of the merged index field
    localparam int BASE_W    = PA_TOP - IDX_LO;        // base kept as bits 55:3
    localparam int PG_LO     = 12;   // page offset bits
    localparam int PG_HI     = 61;   // top page-number bit
    localparam int PAGE_W    = PG_HI - PG_LO + 1;      // 50
    localparam int FMASK_W   = PA_TOP - PG_LO;         // 44
    localparam int SHIFT_W   = 6;
    localparam int MSIZE_W   = 4;
    localparam int SIZE_W    = 5;
    localparam int MASK_BIAS = 5;
    localparam int VALID_BIT = 63;
    localparam int LEAF_BIT  = 62;
    localparam int NLB_LO    = 8;    // next-level base lowest bit
    localparam int NLB_W     = PA_TOP - NLB_LO;        // 48
    localparam int NLB_PAD   = NLB_LO - IDX_LO;        // 5
    localparam int PAD_HI    = PA_W - PA_TOP;          // 8 zero bits on top

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ_WAIT,
        ST_DECODE,
        ST_DONE
    } walk_state_e;
endpackage

// File: rtl/rw_mask_gen.sv
// Module: builds a vector of COUNT low ones, saturating at WIDTH.
// Assumes count is unsigned; counts at or above WIDTH give all ones.
module rw_mask_gen #(
    parameter int WIDTH = 16,
    parameter int CNT_W = 5
) (
    input  logic [CNT_W-1:0] count,
    output logic [WIDTH-1:0] mask
);
    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_bit
            // one bit per position: set when below the count
            assign mask[i] = (32'(count) > i);
        end
    endgenerate
endmodule

// File: rtl/rw_entry_addr.sv
// Module: forms the byte address of the next directory entry.
// The index (page number shifted right) is merged into the base's index
// field under a mask of (msize + MASK_BIAS) low ones. Purely combinational.
module rw_entry_addr
    import radix_walk_pkg::*;
(
    input  logic [BASE_W-1:0]  base,
    input  logic [MSIZE_W-1:0] msize,
    input  logic [SHIFT_W-1:0] shift,
    input  logic [PAGE_W-1:0]  page,
    output logic [PA_W-1:0]    addr
);
    localparam int CNT_W = MSIZE_W + 1;

    logic [CNT_W-1:0] mask_cnt;
    logic [IDX_W-1:0] mask;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] field;

    assign mask_cnt = {1'b0, msize} + CNT_W'(MASK_BIAS);

    rw_mask_gen #(.WIDTH(IDX_W), .CNT_W(CNT_W)) u_mask (
        .count (mask_cnt),
        .mask  (mask)
    );

    // index extraction and merge into the base's index field
    always_comb begin
        idx   = IDX_W'(page >> shift);
        field = (base[IDX_W-1:0] & ~mask) | (idx & mask);
        addr  = {{PAD_HI{1'b0}}, base[BASE_W-1:IDX_W], field, {IDX_LO{1'b0}}};
    end
endmodule

// File: rtl/rw_entry_decode.sv
// Module: checks a directory entry's size field and forms the next base.
// Assumes the caller has already tested the valid and leaf bits.
module rw_entry_decode
    import radix_walk_pkg::*;
#(
    parameter int MIN_SIZE = 5,
    parameter int MAX_SIZE = 16
) (
    input  logic [NLB_W-1:0]   nlb,
    input  logic [SIZE_W-1:0]  size,
    input  logic [SHIFT_W-1:0] shift,
    input  logic               at_limit,
    output logic [BASE_W-1:0]  next_base,
    output logic               bad_tree
);
    // range and depth check, next base alignment
    always_comb begin
        bad_tree  = at_limit
                  || (size < SIZE_W'(MIN_SIZE))
                  || (size > SIZE_W'(MAX_SIZE))
                  || ({1'b0, size} > shift);
        next_base = {nlb, {NLB_PAD{1'b0}}};
    end
endmodule

// File: rtl/rw_leaf_addr.sv
// Module: forms the physical address from a leaf entry.
// Page-number bits below the remaining shift come from the address,
// the rest from the leaf's real page field. Purely combinational.
module rw_leaf_addr
    import radix_walk_pkg::*;
(
    input  logic [PA_TOP-1:0]  pte_lo,
    input  logic [SHIFT_W-1:0] shift,
    input  logic [PAGE_W-1:0]  page,
    output logic [PA_W-1:0]    phys
);
    logic [FMASK_W-1:0] fmask;

    rw_mask_gen #(.WIDTH(FMASK_W), .CNT_W(SHIFT_W)) u_fmask (
        .count (shift),
        .mask  (fmask)
    );

    // merge of real page number and address page bits
    always_comb begin
        phys = {{PAD_HI{1'b0}},
                (pte_lo[PA_TOP-1:PG_LO] & ~fmask) | (page[FMASK_W-1:0] & fmask),
                pte_lo[PG_LO-1:0]};
    end
endmodule

// File: rtl/radix_walk_fsm.sv
// Module: radix page-table walk controller (top).
// Takes root base, mask size and shift from setup, reads one 8-byte entry
// per level over a request/acknowledge port, and ends on a leaf, an invalid
// entry, a malformed size or the depth limit. Assumes rd_ack only arrives
// while rd_req is high.
module radix_walk_fsm
    import radix_walk_pkg::*;
#(
    parameter int MAX_LEVELS = 4,
    parameter int MIN_SIZE   = 5,
    parameter int MAX_SIZE   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [49:0]        start_page,
    input  logic [52:0]        start_base,
    input  logic [3:0]         start_msize,
    input  logic [5:0]         start_shift,
    output logic               rd_req,
    output logic [63:0]        rd_addr,
    input  logic               rd_ack,
    input  logic [63:0]        rd_data,
    output logic               done,
    output logic               err_invalid,
    output logic               err_badtree,
    output logic [63:0]        leaf_pte,
    output logic [63:0]        phys_addr
);
    localparam int LVL_W = $clog2(MAX_LEVELS + 1);

    walk_state_e        state_q;
    logic [PAGE_W-1:0]  page_q;
    logic [BASE_W-1:0]  base_q;
    logic [MSIZE_W-1:0] msize_q;
    logic [SHIFT_W-1:0] shift_q;
    logic [LVL_W-1:0]   level_q;
    logic [PA_W-1:0]    entry_q;
    logic               err_inv_q;
    logic               err_bad_q;
    logic [PA_W-1:0]    phys_q;
    logic [PA_W-1:0]    pte_q;

    logic [PA_W-1:0]    next_addr;
    logic [PA_W-1:0]    leaf_phys;
    logic [BASE_W-1:0]  dec_base;
    logic               dec_bad;
    logic [SIZE_W-1:0]  dec_size;
    logic               at_limit;
    logic               ent_valid;
    logic               ent_leaf;

    assign dec_size  = entry_q[SIZE_W-1:0];
    assign at_limit  = (level_q == LVL_W'(MAX_LEVELS));
    assign ent_valid = entry_q[VALID_BIT];
    assign ent_leaf  = entry_q[LEAF_BIT];

    rw_entry_addr u_addr (
        .base  (base_q),
        .msize (msize_q),
        .shift (shift_q),
        .page  (page_q),
        .addr  (next_addr)
    );

    rw_entry_decode #(.MIN_SIZE(MIN_SIZE), .MAX_SIZE(MAX_SIZE)) u_dec (
        .nlb       (entry_q[PA_TOP-1:NLB_LO]),
        .size      (dec_size),
        .shift     (shift_q),
        .at_limit  (at_limit),
        .next_base (dec_base),
        .bad_tree  (dec_bad)
    );

    rw_leaf_addr u_leaf (
        .pte_lo (entry_q[PA_TOP-1:0]),
        .shift  (shift_q),
        .page   (page_q),
        .phys   (leaf_phys)
    );

    // walk sequencing: latch setup, wait for entries, step levels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            page_q  <= '0;
            base_q  <= '0;
            msize_q <= '0;
            shift_q <= '0;
            level_q <= '0;
            entry_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        page_q  <= start_page;
                        base_q  <= start_base;
                        msize_q <= start_msize;
                        shift_q <= start_shift;
                        level_q <= '0;
                        state_q <= ST_READ_WAIT;
                    end
                end
                ST_READ_WAIT: begin
                    if (rd_ack) begin
                        entry_q <= rd_data;
                        level_q <= level_q + LVL_W'(1);
                        state_q <= ST_DECODE;
                    end
                end
                ST_DECODE: begin
                    if (!ent_valid || ent_leaf || dec_bad) begin
                        state_q <= ST_DONE;
                    end else begin
                        shift_q <= shift_q - {1'b0, dec_size};
                        msize_q <= dec_size[MSIZE_W-1:0];
                        base_q  <= dec_base;
                        state_q <= ST_READ_WAIT;
                    end
                end
                ST_DONE:  state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // outcome registers: cleared on accepted start, set when decoding ends the walk
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_inv_q <= 1'b0;
            err_bad_q <= 1'b0;
            phys_q    <= '0;
            pte_q     <= '0;
        end else if (state_q == ST_IDLE && start) begin
            err_inv_q <= 1'b0;
            err_bad_q <= 1'b0;
            phys_q    <= '0;
            pte_q     <= '0;
        end else if (state_q == ST_DECODE) begin
            if (!ent_valid) begin
                err_inv_q <= 1'b1;
            end else if (ent_leaf) begin
                pte_q  <= entry_q;
                phys_q <= leaf_phys;
            end else if (dec_bad) begin
                err_bad_q <= 1'b1;
            end
        end
    end

    assign rd_req      = (state_q == ST_READ_WAIT);
    assign rd_addr     = next_addr;
    assign done        = (state_q == ST_DONE);
    assign err_invalid = err_inv_q;
    assign err_badtree = err_bad_q;
    assign leaf_pte    = pte_q;
    assign phys_addr   = phys_q;

    // R3: a pending request keeps its address until acknowledged
    a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

    // R9: completion is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: never both error kinds at once
    a_r9_one_error: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(err_invalid && err_badtree));

    // R8: no read is acknowledged once the depth limit has been reached
    a_r8_level_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ack) |-> (level_q < LVL_W'(MAX_LEVELS)));

    // R4: an invalid entry leads straight to done with the invalid flag
    a_r4_invalid_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECODE && !ent_valid) |=> (done && err_invalid));

    // R6: descending a level strictly reduces the remaining shift
    a_r6_shift_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECODE && ent_valid && !ent_leaf && !dec_bad)
        |=> (rd_req && shift_q < $past(shift_q)));

    // R10: a start during a walk leaves the latched address alone
    a_r10_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && start) |=> $stable(page_q));
endmodule

// File: tb/radix_walk_fsm_bench.sv
module radix_walk_fsm_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [49:0] s_page = '0;
    logic [52:0] s_base = '0;
    logic [3:0]  s_ms = '0;
    logic [5:0]  s_sh = '0;
    logic        rd_req;
    logic [63:0] rd_addr;
    logic        rd_ack = 1'b0;
    logic [63:0] rd_data = '0;
    logic        done, err_invalid, err_badtree;
    logic [63:0] leaf_pte, phys_addr;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [63:0] chain [0:7];

    always #10 clk = ~clk;

    radix_walk_fsm u_radix_walk_fsm (
        .clk(clk), .rst_n(rst_n), .start(start),
        .start_page(s_page), .start_base(s_base),
        .start_msize(s_ms), .start_shift(s_sh),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
        .done(done), .err_invalid(err_invalid), .err_badtree(err_badtree),
        .leaf_pte(leaf_pte), .phys_addr(phys_addr)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL R3 watchdog expired actual=%0d expected<150000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_addr(logic [52:0] b, logic [3:0] ms,
                                             logic [5:0] sh, logic [49:0] pg);
        logic [15:0] m;
        logic [15:0] ix;
        int c;
        c = int'(ms) + 5;
        if (c >= 16) m = 16'hFFFF;
        else m = (16'd1 << c) - 16'd1;
        ix = 16'(pg >> sh);
        return {8'b0, b[52:16], (b[15:0] & ~m) | (ix & m), 3'b0};
    endfunction

    function automatic logic [63:0] exp_phys(logic [63:0] pte, logic [5:0] sh, logic [49:0] pg);
        logic [43:0] fm;
        if (sh >= 6'd44) fm = '1;
        else fm = (44'd1 << sh) - 44'd1;
        return {8'b0, (pte[55:12] & ~fm) | (pg[43:0] & fm), pte[11:0]};
    endfunction

    function automatic logic [63:0] rand_entry();
        logic [63:0] e;
        int r;
        e = {$urandom, $urandom};
        r = $urandom_range(0, 9);
        e[63] = 1'b1;
        e[62] = 1'b0;
        if (r == 0) e[63] = 1'b0;
        else if (r <= 2) e[62] = 1'b1;
        else if (r == 3) e[4:0] = 5'($urandom);
        else e[4:0] = 5'($urandom_range(5, 16));
        return e;
    endfunction

    function automatic logic [63:0] dir_entry(logic [47:0] nlb, logic [4:0] sz);
        return {1'b1, 1'b0, 6'h0, nlb, 3'b0, sz};
    endfunction

    // one walk: serve reads from chain[], check each address, then the outcome
    task automatic run_walk(input logic [49:0] pg, input logic [52:0] base,
                            input logic [3:0] ms, input logic [5:0] sh, input bit poke);
        logic [52:0] mb;
        logic [3:0]  mm;
        logic [5:0]  msh;
        logic [63:0] e, xa, xphys, xpte;
        bit          fin, xinv, xbad;
        int          lvl, n, d;
        mb = base; mm = ms; msh = sh; lvl = 0; fin = 0;
        xinv = 0; xbad = 0; xphys = '0; xpte = '0;
        @(negedge clk);
        start = 1'b1; s_page = pg; s_base = base; s_ms = ms; s_sh = sh;
        @(negedge clk);
        start = 1'b0;
        s_page = ~pg; s_base = ~base; s_ms = ~ms; s_sh = ~sh;
        while (!fin) begin
            n = 0;
            while (!rd_req && n < 40) begin @(negedge clk); n++; end
            check((lvl == 0) ? "R2 first entry address" : "R6 next entry address",
                  rd_addr, exp_addr(mb, mm, msh, pg));
            xa = rd_addr;
            d = poke ? 2 : $urandom_range(0, 3);
            for (int k = 0; k < d; k++) begin
                if (poke) start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                check("R3 request held", {63'b0, rd_req}, 64'd1);
                check("R3 address stable", rd_addr, xa);
            end
            rd_ack = 1'b1;
            rd_data = chain[lvl];
            @(negedge clk);
            rd_ack = 1'b0;
            rd_data = {$urandom, $urandom};
            e = chain[lvl];
            lvl++;
            if (!e[63]) begin
                xinv = 1; fin = 1;
            end else if (e[62]) begin
                xpte = e; xphys = exp_phys(e, msh, pg); fin = 1;
            end else if (lvl == 4 || e[4:0] < 5 || e[4:0] > 16 || {1'b0, e[4:0]} > msh) begin
                xbad = 1; fin = 1;
            end else begin
                msh = msh - {1'b0, e[4:0]};
                mm  = e[3:0];
                mb  = {e[55:8], 5'b0};
            end
        end
        n = 0;
        while (!done && n < 40) begin
            if (rd_req) check("R8 no read after final entry", {63'b0, rd_req}, 64'd0);
            @(negedge clk);
            n++;
        end
        check("R9 done pulse seen", {63'b0, done}, 64'd1);
        check("R4 invalid flag", {63'b0, err_invalid}, {63'b0, xinv});
        check("R5 R8 bad-tree flag", {63'b0, err_badtree}, {63'b0, xbad});
        check("R7 physical address", phys_addr, xphys);
        check("R7 leaf entry", leaf_pte, xpte);
        @(negedge clk);
        check("R9 done lasts one cycle", {63'b0, done}, 64'd0);
        check("R9 result held", phys_addr, xphys);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 no request in reset", {63'b0, rd_req}, 64'd0);
        check("R1 no done in reset", {63'b0, done}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", {62'b0, rd_req, done}, 64'd0);
        check("R1 flags clear", {62'b0, err_invalid, err_badtree}, 64'd0);
        check("R1 phys clear", phys_addr, 64'd0);
        check("R1 pte clear", leaf_pte, 64'd0);

        // R7: leaf at root
        chain[0] = 64'hC0AB_CDEF_1234_5678;
        run_walk(50'h2_3456_789A_BCDE, 53'h1F_2345_6789_ABC8, 4'd8, 6'd20, 0);
        // R4: invalid root entry
        chain[0] = 64'h3FFF_FFFF_FFFF_FFFF;
        run_walk(50'h1234, 53'h4000, 4'd3, 6'd30, 0);
        // R5: size below range, above range, above shift
        chain[0] = dir_entry(48'h1234, 5'd4);
        run_walk(50'h5555, 53'h8000, 4'd4, 6'd40, 0);
        chain[0] = dir_entry(48'h1234, 5'd17);
        run_walk(50'h5555, 53'h8000, 4'd4, 6'd40, 0);
        chain[0] = dir_entry(48'h1234, 5'd9);
        run_walk(50'h5555, 53'h8000, 4'd4, 6'd8, 0);
        // R5 R6: size equal to shift accepted, then leaf with zero shift
        chain[0] = dir_entry(48'hABCDE, 5'd10);
        chain[1] = 64'hC000_0000_7777_7123;
        run_walk(50'h3_FFFF_FFFF_FFFF, 53'h2_0000, 4'd2, 6'd10, 0);
        // R6: size 16 gives mask size 0
        chain[0] = dir_entry(48'h7_0000, 5'd16);
        chain[1] = 64'hC000_0012_3456_7FFF;
        run_walk(50'h2_AAAA_AAAA_AAAA, 53'h1_0000, 4'd15, 6'd40, 0);
        // R8: three directories then leaf is fine; four directories is too deep
        chain[0] = dir_entry(48'h100, 5'd5);
        chain[1] = dir_entry(48'h200, 5'd6);
        chain[2] = dir_entry(48'h300, 5'd7);
        chain[3] = 64'hC000_00FE_DCBA_9ABC;
        run_walk(50'h1_2345_6789_ABCD, 53'h40, 4'd5, 6'd40, 0);
        chain[3] = dir_entry(48'h400, 5'd5);
        run_walk(50'h1_2345_6789_ABCD, 53'h40, 4'd5, 6'd40, 0);
        // R10: start pulses during pending reads are ignored
        chain[0] = dir_entry(48'h9999, 5'd9);
        chain[1] = 64'hC000_0055_6677_8899;
        run_walk(50'h0_F0F0_F0F0_F0F0, 53'h3_0000, 4'd6, 6'd35, 1);

        // random walks
        for (int w = 0; w < 300; w++) begin
            for (int j = 0; j < 8; j++) chain[j] = rand_entry();
            run_walk({$urandom, 18'($urandom)}, {$urandom, 21'($urandom)},
                     4'($urandom), 6'($urandom_range(20, 63)), ($urandom_range(0, 7) == 0));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule